// File: doc/BRIEF.md
# Sequential Floating-Point Adder

This block adds two numbers, each held as a two's-complement fractional mantissa paired with a signed exponent, so that an operand stands for M·2^E. A pulse on `start` while the block is idle captures both operands. The exponents are compared and the operand with the larger exponent is kept as the base. The mantissa of the other operand is shifted right arithmetically, one place per clock, until both share the larger exponent. The aligned mantissas are then added. The sum is brought into normal form by left shifts, one per clock, and `done` pulses once the result is ready.

The mantissa is a sign bit followed by `MANT_W-1` fraction bits, giving a range of [-1, 1). A result counts as normal when its top two bits differ. The lowest exponent value, a one followed by zeros, serves as the floor of the range and as the exponent that marks a zero result. Rounding, special values and subnormal handling are not part of this block.

The control state machine has five states:

| State | Role |
|---|---|
| IDLE | Waits for `start`. |
| ALIGN | Shifts the smaller operand's mantissa right. |
| ADD | Sums the mantissas and handles overflow or zero. |
| NORM | Shifts the sum left until it is normal. |
| DONE | Raises `done` for one cycle. |

The transitions are:

- IDLE→ALIGN on `start` when a shift is needed.
- IDLE→ADD on `start` when no shift is needed or the operand is flushed to zero.
- ALIGN→ALIGN while more than one shift remains.
- ALIGN→ADD on the last shift.
- ADD→DONE on a zero sum.
- ADD→NORM otherwise.
- NORM→NORM while the mantissa is not normal and the exponent is above its minimum.
- NORM→DONE otherwise.
- DONE→IDLE always.

Top module: `fpa_add`

## Requirements
- R1: After reset, `busy` and `done` are 0, and `res_mant` and `res_exp` are both 0.
- R2: A `start` seen while idle makes `busy` 1 from the next cycle until `done` has pulsed. A `start` seen while `busy` is 1 is ignored, and the result reflects only the operands captured at the accepted start.
- R3: With unequal exponents, the result is computed at the larger exponent. The other mantissa is shifted right arithmetically by the exponent difference, and the low bits are truncated.
- R4: With equal exponents, the mantissas are added with no shift, at that exponent.
- R5: When the exponent difference is `MANT_W` (12) or more, the smaller operand contributes zero. A difference of 11 still shifts normally, so a mantissa of -1 becomes 0xFFF.
- R6: If the 13-bit sum of the sign-extended mantissas overflows the 12-bit range, the sum is shifted right by one (keeping its sign) and the exponent is incremented.
- R7: A nonzero sum whose bits 11 and 10 are equal is shifted left by one per cycle, decrementing the exponent each time, until those bits differ.
- R8: A zero sum gives `res_mant` = 0 and `res_exp` = the minimum exponent (6'h20 = -32), with no normalization.
- R9: Normalization stops when the exponent reaches the minimum (-32), even if the mantissa is not yet normal.
- R10: `done` is high for exactly one cycle, and `busy` is 0 in the cycle after it. `res_mant` and `res_exp` stay unchanged from `done` until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request to add the presented operands |
| a_mant | input | MANT_W | Operand A mantissa, two's-complement fraction |
| a_exp | input | EXP_W | Operand A exponent, two's complement |
| b_mant | input | MANT_W | Operand B mantissa, two's-complement fraction |
| b_exp | input | EXP_W | Operand B exponent, two's complement |
| busy | output | 1 | High while an addition is in progress |
| done | output | 1 | One-cycle pulse when the result is valid |
| res_mant | output | MANT_W | Result mantissa |
| res_exp | output | EXP_W | Result exponent |

## Verification
The bench builds the adder with its default widths: a 12-bit mantissa and a 6-bit exponent. With these widths, an exponent difference can reach 63. This brings the flush-to-zero path (differences of 12 and 20) and the last real shift (difference 11) within easy reach. The minimum exponent of -32 is close enough that an operand near it reaches the normalization floor after a few left shifts. Overflow in both signs, exact cancellation, and a start issued mid-operation are driven with hand-computed expected mantissas and exponents.

// File: rtl/fpa_pkg.sv
package fpa_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ALIGN,
        ST_ADD,
        ST_NORM,
        ST_DONE
    } fpa_state_e;

endpackage

// File: rtl/fpa_exp_cmp.sv
module fpa_exp_cmp #(
    parameter int MANT_W = 12,
    parameter int EXP_W  = 6
) (
    input  logic [MANT_W-1:0] a_mant,
    input  logic [EXP_W-1:0]  a_exp,
    input  logic [MANT_W-1:0] b_mant,
    input  logic [EXP_W-1:0]  b_exp,
    output logic [MANT_W-1:0] base_mant,
    output logic [MANT_W-1:0] minor_mant,
    output logic [EXP_W-1:0]  base_exp,
    output logic [EXP_W:0]    shift_amt,
    output logic              flush
);
    localparam logic [EXP_W:0] MANT_W_L = (EXP_W+1)'(MANT_W);

    logic            a_ge_b;
    logic [EXP_W:0]  a_ext;
    logic [EXP_W:0]  b_ext;

    always_comb begin
        a_ext  = {a_exp[EXP_W-1], a_exp};
        b_ext  = {b_exp[EXP_W-1], b_exp};
        a_ge_b = ($signed(a_exp) >= $signed(b_exp));
        if (a_ge_b) begin
            base_mant  = a_mant;
            minor_mant = b_mant;
            base_exp   = a_exp;
            shift_amt  = a_ext - b_ext;
        end else begin
            base_mant  = b_mant;
            minor_mant = a_mant;
            base_exp   = b_exp;
            shift_amt  = b_ext - a_ext;
        end
        flush = (shift_amt >= MANT_W_L);
    end
endmodule

// File: rtl/fpa_mant_add.sv
module fpa_mant_add #(
    parameter int MANT_W = 12
) (
    input  logic [MANT_W-1:0] x_mant,
    input  logic [MANT_W-1:0] y_mant,
    output logic [MANT_W-1:0] sum_mant,
    output logic              ovf,
    output logic              is_zero
);
    logic [MANT_W:0] wide_sum;

    always_comb begin
        wide_sum = {x_mant[MANT_W-1], x_mant} + {y_mant[MANT_W-1], y_mant};
        ovf      = wide_sum[MANT_W] ^ wide_sum[MANT_W-1];
        is_zero  = (wide_sum == '0);
        sum_mant = ovf ? wide_sum[MANT_W:1] : wide_sum[MANT_W-1:0];
    end
endmodule

// File: rtl/fpa_norm_chk.sv
module fpa_norm_chk #(
    parameter int MANT_W = 12
) (
    input  logic [MANT_W-1:0] mant,
    output logic              normed
);
    always_comb begin
        normed = mant[MANT_W-1] ^ mant[MANT_W-2];
    end
endmodule

// File: rtl/fpa_add.sv
module fpa_add
    import fpa_pkg::*;
#(
    parameter int MANT_W = 12,
    parameter int EXP_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [MANT_W-1:0] a_mant,
    input  logic [EXP_W-1:0]  a_exp,
    input  logic [MANT_W-1:0] b_mant,
    input  logic [EXP_W-1:0]  b_exp,
    output logic              busy,
    output logic              done,
    output logic [MANT_W-1:0] res_mant,
    output logic [EXP_W-1:0]  res_exp
);
    localparam logic [EXP_W-1:0] EXP_MIN = {1'b1, {(EXP_W-1){1'b0}}};
    localparam logic [EXP_W:0]   CNT_ONE = (EXP_W+1)'(1);

    fpa_state_e state_q, state_d;

    logic [MANT_W-1:0] acc_q;
    logic [MANT_W-1:0] aux_q;
    logic [EXP_W-1:0]  exp_q;
    logic [EXP_W:0]    cnt_q;

    logic [MANT_W-1:0] base_mant, minor_mant;
    logic [EXP_W-1:0]  base_exp;
    logic [EXP_W:0]    shift_amt;
    logic              flush;
    logic [MANT_W-1:0] sum_mant;
    logic              sum_ovf, sum_zero;
    logic              normed;
    logic              at_floor;

    fpa_exp_cmp #(.MANT_W(MANT_W), .EXP_W(EXP_W)) u_cmp (
        .a_mant     (a_mant),
        .a_exp      (a_exp),
        .b_mant     (b_mant),
        .b_exp      (b_exp),
        .base_mant  (base_mant),
        .minor_mant (minor_mant),
        .base_exp   (base_exp),
        .shift_amt  (shift_amt),
        .flush      (flush)
    );

    fpa_mant_add #(.MANT_W(MANT_W)) u_add (
        .x_mant   (acc_q),
        .y_mant   (aux_q),
        .sum_mant (sum_mant),
        .ovf      (sum_ovf),
        .is_zero  (sum_zero)
    );

    fpa_norm_chk #(.MANT_W(MANT_W)) u_norm (
        .mant   (acc_q),
        .normed (normed)
    );

    assign at_floor = (exp_q == EXP_MIN);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    if (flush || shift_amt == '0) state_d = ST_ADD;
                    else                          state_d = ST_ALIGN;
                end
            end
            ST_ALIGN: begin
                if (cnt_q == CNT_ONE) state_d = ST_ADD;
            end
            ST_ADD: begin
                state_d = sum_zero ? ST_DONE : ST_NORM;
            end
            ST_NORM: begin
                if (normed || at_floor) state_d = ST_DONE;
            end
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q <= '0;
            aux_q <= '0;
            exp_q <= '0;
            cnt_q <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        acc_q <= base_mant;
                        aux_q <= flush ? '0 : minor_mant;
                        exp_q <= base_exp;
                        cnt_q <= flush ? '0 : shift_amt;
                    end
                end
                ST_ALIGN: begin
                    aux_q <= $signed(aux_q) >>> 1;
                    cnt_q <= cnt_q - CNT_ONE;
                end
                ST_ADD: begin
                    if (sum_zero) begin
                        acc_q <= '0;
                        exp_q <= EXP_MIN;
                    end else begin
                        acc_q <= sum_mant;
                        exp_q <= exp_q + EXP_W'(sum_ovf);
                    end
                end
                ST_NORM: begin
                    if (!normed && !at_floor) begin
                        acc_q <= acc_q << 1;
                        exp_q <= exp_q - EXP_W'(1);
                    end
                end
                ST_DONE: ;
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        busy     = (state_q != ST_IDLE);
        done     = (state_q == ST_DONE);
        res_mant = acc_q;
        res_exp  = exp_q;
    end
endmodule

// File: rtl/fpa_add_chk.sv
module fpa_add_chk #(
    parameter int MANT_W = 12,
    parameter int EXP_W  = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              busy,
    input logic              done,
    input logic [MANT_W-1:0] res_mant,
    input logic [EXP_W-1:0]  res_exp
);
    localparam logic [EXP_W-1:0] EXP_MIN = {1'b1, {(EXP_W-1){1'b0}}};

    // R2
    start_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));

    // R10
    done_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy);

    // R8
    zero_exp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && res_mant == '0) |-> (res_exp == EXP_MIN));

    // R7
    normal_form_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && res_mant != '0 && res_exp != EXP_MIN)
            |-> (res_mant[MANT_W-1] != res_mant[MANT_W-2]));

    // R10
    hold_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> ($stable(res_mant) && $stable(res_exp)));
endmodule

bind fpa_add fpa_add_chk #(.MANT_W(MANT_W), .EXP_W(EXP_W)) u_fpa_add_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .busy     (busy),
    .done     (done),
    .res_mant (res_mant),
    .res_exp  (res_exp)
);

// File: tb/tb_fpa_add.sv
module tb_fpa_add;
    localparam int MW = 12;
    localparam int EW = 6;
    localparam int NVEC = 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [MW-1:0] a_mant = '0;
    logic [EW-1:0] a_exp = '0;
    logic [MW-1:0] b_mant = '0;
    logic [EW-1:0] b_exp = '0;
    logic          busy, done;
    logic [MW-1:0] res_mant;
    logic [EW-1:0] res_exp;

    int checks = 0;
    int failures = 0;
    int cycles = 0;

    always #10 clk = ~clk;

    fpa_add #(.MANT_W(MW), .EXP_W(EW)) dut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .a_mant(a_mant), .a_exp(a_exp), .b_mant(b_mant), .b_exp(b_exp),
        .busy(busy), .done(done), .res_mant(res_mant), .res_exp(res_exp)
    );

    // {a_mant, a_exp, b_mant, b_exp, exp_mant, exp_exp}
    localparam logic [53:0] VEC [NVEC] = '{
        {12'h400, 6'h00, 12'h400, 6'h00, 12'h400, 6'h01},
        {12'h400, 6'h02, 12'h400, 6'h00, 12'h500, 6'h02},
        {12'h100, 6'h00, 12'h100, 6'h03, 12'h480, 6'h01},
        {12'h400, 6'h00, 12'hC00, 6'h00, 12'h000, 6'h20},
        {12'hC00, 6'h01, 12'hE00, 6'h00, 12'hB00, 6'h01},
        {12'h800, 6'h00, 12'h800, 6'h00, 12'h800, 6'h01},
        {12'h400, 6'h14, 12'h7FF, 6'h00, 12'h400, 6'h14},
        {12'h400, 6'h0B, 12'h800, 6'h00, 12'h7FE, 6'h0A},
        {12'h400, 6'h0C, 12'h800, 6'h00, 12'h400, 6'h0C},
        {12'h200, 6'h3D, 12'h200, 6'h3D, 12'h400, 6'h3D},
        {12'h001, 6'h22, 12'h000, 6'h20, 12'h004, 6'h20},
        {12'h600, 6'h00, 12'hA00, 6'h01, 12'hA00, 6'h00}
    };

    function automatic string vec_tag(int i);
        case (i)
            0:       return "R6";
            1:       return "R3";
            2:       return "R7";
            3:       return "R8";
            4:       return "R3";
            5:       return "R6";
            6:       return "R5";
            7:       return "R5";
            8:       return "R5";
            9:       return "R4";
            10:      return "R9";
            default: return "R7";
        endcase
    endfunction

    task automatic check(input string req, input string what,
                         input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, got, exp);
        end
    endtask

    task automatic wait_done(output bit ok);
        ok = 1'b0;
        for (int k = 0; k < 200; k++) begin
            @(negedge clk);
            if (done === 1'b1) begin
                ok = 1'b1;
                break;
            end
        end
    endtask

    task automatic issue(input logic [MW-1:0] am, input logic [EW-1:0] ae,
                         input logic [MW-1:0] bm, input logic [EW-1:0] be);
        a_mant = am; a_exp = ae; b_mant = bm; b_exp = be;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    // watchdog
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000) begin
            checks++;
            failures++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        bit ok;
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1", "busy", 32'(busy), 0);
        check("R1", "done", 32'(done), 0);
        check("R1", "res_mant", 32'(res_mant), 0);
        check("R1", "res_exp", 32'(res_exp), 0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NVEC; i++) begin
            issue(VEC[i][53:42], VEC[i][41:36], VEC[i][35:24], VEC[i][23:18]);
            wait_done(ok);
            check(vec_tag(i), "done seen", 32'(ok), 1);
            check(vec_tag(i), "res_mant", 32'(res_mant), 32'(VEC[i][17:6]));
            check(vec_tag(i), "res_exp", 32'(res_exp), 32'(VEC[i][5:0]));
            @(negedge clk);
        end

        // R10: done pulse width, busy drop, result held
        issue(12'h400, 6'h02, 12'h400, 6'h00);
        wait_done(ok);
        @(negedge clk);
        check("R10", "done after pulse", 32'(done), 0);
        check("R10", "busy after pulse", 32'(busy), 0);
        repeat (5) @(negedge clk);
        check("R10", "held mant", 32'(res_mant), 32'h500);
        check("R10", "held exp", 32'(res_exp), 32'h02);

        // R2: start while busy ignored
        issue(12'h100, 6'h00, 12'h100, 6'h03);
        check("R2", "busy after start", 32'(busy), 1);
        a_mant = 12'h400; a_exp = 6'h00; b_mant = 12'h400; b_exp = 6'h00;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_done(ok);
        check("R2", "done seen", 32'(ok), 1);
        check("R2", "res_mant", 32'(res_mant), 32'h480);
        check("R2", "res_exp", 32'(res_exp), 32'h01);
        repeat (4) @(negedge clk);
        check("R2", "no second run", 32'(busy), 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule